// File: doc/BRIEF.md
# Register-driven serial flash controller

This block is a bus-slave controller for serial NOR flash parts on an SPI link. Software reaches it through a small register port holding five words: a configuration word, a command word, a status word, a transmit word and a receive word. The configuration word picks the operating style, enables the four chip-selected banks and sets the serial clock divisor. Writing the command word starts a transfer.

In software style the controller shifts out one to four bytes from the transmit word, lowest byte first. It then clocks in zero to four reply bytes and packs them into the receive word, again lowest byte first. In hardware style a single command bit issues either a write-enable opcode or a read-status opcode to the chosen bank. The controller keeps a write-enable flag for each bank and places the returned flash status byte in the low byte of its status word.

Transfers run in SPI mode 0, most significant bit first within each byte. One chip select is active for the whole transfer. It is followed by an enforced idle gap before the next transfer. A command written to a disabled bank does not reach the wire and sets an error flag. So does a command written while the controller is busy.

Top module: `sflash_ctrl`

## Requirements
- R1: Register word addresses are 0 config, 1 command, 2 status, 3 transmit, 4 receive. After reset every register reads 0, all chip selects are high and the serial clock is low. The config word keeps bits 28, 15, 11:8 and 3:0, and the other config bits read 0.
- R2: The serial clock period is 2*D bus cycles, where D is config bits 11:8, and a D of 0 acts as 1. The clock idles low (mode 0).
- R3: With config bit 28 at 1 (software style), a command write with bit 7 set sends N bytes from the transmit word, where N is command bits 2:0. Bits 7:0 go first, then 15:8 and so on, each byte MSB first. N values of 0 act as 1 and values above 4 act as 4.
- R4: In software style, R reply bytes follow the transmit bytes, where R is command bits 6:4. The first reply byte lands in receive bits 7:0, the next in 15:8, and so on. R values above 4 act as 4, and an R of 0 means no reply.
- R5: Status bit 8 sets when a transfer ends. A status write with bit 8 at 0 clears it, and a write with that bit at 1 leaves it unchanged.
- R6: With config bit 28 at 0 (hardware style), command bit 11 sends opcode 0x06 to bank B (command bits 13:12). When the transfer ends it sets status bit 12+B.
- R7: In hardware style with command bit 11 at 0, command bit 10 sends opcode 0x05 and reads one byte. That byte appears in status bits 7:0, so status bit 0 shows write-in-progress.
- R8: If a read-status reply has bit 0 at 0 while the bank's write-enable flag is set, status bit 9 (write complete) sets. Status bits 9, 10, 11 and 15:12 each clear when written as 0.
- R9: Only chip select B is low, from the first transmitted bit to the last received bit. All selects then stay high for at least 4*D bus cycles (two serial clock periods) before the next transfer. Status bit 16 reads 1 for the whole of that time.
- R10: A command write while status bit 16 is 1 is ignored: no transfer starts, the command word keeps its value, and status bit 11 (error 2) sets.
- R11: A command write that targets a bank whose config enable bit (bit B of 3:0) is 0 sets status bit 10 (error 1) on the next cycle. It produces no chip select or clock activity and does not set status bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |
| cs_no | output | 4 | Bank chip selects, active low |

## Verification
A register read is valid in the same cycle its address is presented. The bench samples it 1 ns after a falling edge. The effects of a command write appear right after the rising edge that takes the write: a chip select going low, or error 1 or error 2 setting. The bench reads the status word on the falling edge that follows the write. A transfer keeps status bit 16 high for (N+R)*8*2*D bus cycles plus the 4*D-cycle gap. The transfer-finished flag, the write-enable flag and the status byte update on the same edge that lowers bit 16, so the bench polls bit 16 and checks results on the first read where it is 0. Clock period and chip-select gap are measured in simulation time against 20*D ns and 40*D ns.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam logic [2:0] A_CFG = 3'd0;
  localparam logic [2:0] A_CMD = 3'd1;
  localparam logic [2:0] A_STS = 3'd2;
  localparam logic [2:0] A_TXD = 3'd3;
  localparam logic [2:0] A_RXD = 3'd4;

  localparam logic [31:0] CFG_MASK = 32'h1000_8F0F;
  localparam int CFG_SW   = 28;
  localparam int CMD_SEND = 7;
  localparam int CMD_RDSR = 10;
  localparam int CMD_WREN = 11;
  localparam int CMD_BANK = 12;

  localparam int ST_TFF  = 8;
  localparam int ST_WCF  = 9;
  localparam int ST_ERR1 = 10;
  localparam int ST_ERR2 = 11;
  localparam int ST_WM   = 12;
  localparam int ST_BUSY = 16;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_GAP} eng_state_e;
  typedef enum logic [1:0] {OP_RAW, OP_WE, OP_RS} op_e;

  function automatic logic [2:0] clamp_len(input logic [2:0] v, input logic [2:0] lo);
    if (v < lo) return lo;
    if (v > 3'd4) return 3'd4;
    return v;
  endfunction
endpackage

// File: rtl/sflash_shifter.sv
module sflash_shifter
  import sflash_pkg::*;
#(
  parameter int DIVW    = 4,
  parameter int MAXB    = 4,
  parameter int GAP_SCK = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [8*MAXB-1:0]   tx_word_i,
  input  logic [2:0]          tx_bytes_i,
  input  logic [2:0]          rx_bytes_i,
  input  logic [DIVW-1:0]     div_i,
  input  logic                miso_i,
  output logic                busy_o,
  output logic                sel_o,
  output logic                done_o,
  output logic                sck_o,
  output logic                mosi_o,
  output logic [8*MAXB-1:0]   rx_word_o
);
  localparam int WW  = 8 * MAXB;
  localparam int BIW = $clog2(WW);
  localparam int NW  = $clog2(2 * WW) + 1;
  localparam int GW  = DIVW + $clog2(2 * GAP_SCK) + 1;

  eng_state_e     st_q;
  logic [DIVW-1:0] div_q, hc_q;
  logic [NW-1:0]  n_q, txbits_q, tot_q, m_w;
  logic [GW-1:0]  gc_q, glen_w;
  logic [WW-1:0]  tx_q, rx_q;
  logic           sck_q;

  assign m_w    = n_q - txbits_q;
  assign glen_w = GW'(div_q) * GW'(2 * GAP_SCK);
  assign done_o = (st_q == ENG_GAP) && (gc_q == glen_w - GW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ENG_IDLE; div_q <= '0; hc_q <= '0; n_q <= '0;
      txbits_q <= '0; tot_q <= '0; gc_q <= '0;
      tx_q <= '0; rx_q <= '0; sck_q <= 1'b0;
    end else begin
      unique case (st_q)
        ENG_IDLE: if (start_i) begin
          st_q     <= ENG_SHIFT;
          div_q    <= div_i;
          tx_q     <= tx_word_i;
          txbits_q <= NW'(tx_bytes_i) << 3;
          tot_q    <= (NW'(tx_bytes_i) + NW'(rx_bytes_i)) << 3;
          n_q      <= '0;
          hc_q     <= '0;
          rx_q     <= '0;
          sck_q    <= 1'b0;
        end
        ENG_SHIFT: begin
          if (hc_q == div_q - DIVW'(1)) begin
            hc_q <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              if (n_q >= txbits_q) rx_q[{m_w[BIW-1:3], ~m_w[2:0]}] <= miso_i;
            end else begin
              sck_q <= 1'b0;
              if (n_q == tot_q - NW'(1)) begin
                st_q <= ENG_GAP;
                gc_q <= '0;
              end else begin
                n_q <= n_q + NW'(1);
              end
            end
          end else begin
            hc_q <= hc_q + DIVW'(1);
          end
        end
        ENG_GAP: begin
          if (done_o) st_q <= ENG_IDLE;
          else gc_q <= gc_q + GW'(1);
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ENG_IDLE);
  assign sel_o     = (st_q == ENG_SHIFT);
  assign sck_o     = sck_q;
  assign mosi_o    = (st_q == ENG_SHIFT) && (n_q < txbits_q) && tx_q[{n_q[BIW-1:3], ~n_q[2:0]}];
  assign rx_word_o = rx_q;
endmodule

// File: rtl/sflash_cmd.sv
module sflash_cmd
  import sflash_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int MAXB  = 4,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic              wr_i,
  input  logic              busy_i,
  input  logic              sw_mode_i,
  input  logic [31:0]       cmd_i,
  input  logic [NBANK-1:0]  bank_en_i,
  input  logic [8*MAXB-1:0] txd_i,
  output logic              accept_o,
  output logic              launch_o,
  output logic              bad_bank_o,
  output logic              collide_o,
  output op_e               op_o,
  output logic [BW-1:0]     bank_o,
  output logic [8*MAXB-1:0] tx_word_o,
  output logic [2:0]        tx_bytes_o,
  output logic [2:0]        rx_bytes_o
);
  logic req;

  assign accept_o  = wr_i && !busy_i;
  assign collide_o = wr_i && busy_i;
  assign bank_o    = cmd_i[CMD_BANK +: BW];

  always_comb begin
    if (sw_mode_i) begin
      req        = cmd_i[CMD_SEND];
      op_o       = OP_RAW;
      tx_word_o  = txd_i;
      tx_bytes_o = clamp_len(cmd_i[2:0], 3'd1);
      rx_bytes_o = clamp_len(cmd_i[6:4], 3'd0);
    end else begin
      req        = cmd_i[CMD_WREN] | cmd_i[CMD_RDSR];
      op_o       = cmd_i[CMD_WREN] ? OP_WE : OP_RS;
      tx_word_o  = (8*MAXB)'(cmd_i[CMD_WREN] ? OP_WREN : OP_RDSR);
      tx_bytes_o = 3'd1;
      rx_bytes_o = cmd_i[CMD_WREN] ? 3'd0 : 3'd1;
    end
  end

  assign launch_o   = accept_o && req && bank_en_i[bank_o];
  assign bad_bank_o = accept_o && req && !bank_en_i[bank_o];
endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
  import sflash_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int DIVW    = 4,
  parameter int GAP_SCK = 2,
  localparam int MAXB   = 4,
  localparam int BW     = $clog2(NBANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [NBANK-1:0] cs_no
);
  logic [31:0] cfg_q, cmd_q, txd_q, rx_w, tx_word;
  logic [7:0]  sr_byte_q;
  logic        tff_q, wcf_q, err1_q, err2_q;
  logic [NBANK-1:0] wm_q;
  logic [BW-1:0] bank_q, bank_w;
  op_e         op_q, op_w;
  logic        cmd_wr, sts_wr, accept, launch, bad_bank, collide;
  logic        eng_busy, eng_sel, eng_done;
  logic [2:0]  txb, rxb;
  logic [DIVW-1:0] div_w;

  assign cmd_wr = reg_we_i && (reg_addr_i == A_CMD);
  assign sts_wr = reg_we_i && (reg_addr_i == A_STS);
  assign div_w  = (cfg_q[11:8] == 4'd0) ? DIVW'(1) : DIVW'(cfg_q[11:8]);

  sflash_cmd #(.NBANK(NBANK), .MAXB(MAXB)) cmd_i (
    .wr_i(cmd_wr), .busy_i(eng_busy), .sw_mode_i(cfg_q[CFG_SW]),
    .cmd_i(reg_wdata_i), .bank_en_i(cfg_q[NBANK-1:0]), .txd_i(txd_q),
    .accept_o(accept), .launch_o(launch), .bad_bank_o(bad_bank),
    .collide_o(collide), .op_o(op_w), .bank_o(bank_w), .tx_word_o(tx_word),
    .tx_bytes_o(txb), .rx_bytes_o(rxb)
  );

  sflash_shifter #(.DIVW(DIVW), .MAXB(MAXB), .GAP_SCK(GAP_SCK)) eng_i (
    .clk_i, .rst_ni, .start_i(launch), .tx_word_i(tx_word),
    .tx_bytes_i(txb), .rx_bytes_i(rxb), .div_i(div_w), .miso_i,
    .busy_o(eng_busy), .sel_o(eng_sel), .done_o(eng_done),
    .sck_o, .mosi_o, .rx_word_o(rx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0; cmd_q <= '0; txd_q <= '0;
      bank_q <= '0; op_q <= OP_RAW;
      sr_byte_q <= '0; tff_q <= 1'b0; wcf_q <= 1'b0;
      err1_q <= 1'b0; err2_q <= 1'b0; wm_q <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == A_CFG) cfg_q <= reg_wdata_i & CFG_MASK;
      if (reg_we_i && reg_addr_i == A_TXD) txd_q <= reg_wdata_i;
      if (accept) cmd_q <= reg_wdata_i;
      if (launch) begin
        bank_q <= bank_w;
        op_q   <= op_w;
      end
      // write-0-to-clear first, hardware set events win
      if (sts_wr) begin
        tff_q  <= tff_q  & reg_wdata_i[ST_TFF];
        wcf_q  <= wcf_q  & reg_wdata_i[ST_WCF];
        err1_q <= err1_q & reg_wdata_i[ST_ERR1];
        err2_q <= err2_q & reg_wdata_i[ST_ERR2];
        wm_q   <= wm_q   & reg_wdata_i[ST_WM +: NBANK];
      end
      if (bad_bank) err1_q <= 1'b1;
      if (collide)  err2_q <= 1'b1;
      if (eng_done) begin
        tff_q <= 1'b1;
        if (op_q == OP_WE) wm_q[bank_q] <= 1'b1;
        if (op_q == OP_RS) begin
          sr_byte_q <= rx_w[7:0];
          if (!rx_w[0] && wm_q[bank_q]) wcf_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CFG: reg_rdata_o = cfg_q;
      A_CMD: reg_rdata_o = cmd_q;
      A_STS: begin
        reg_rdata_o[7:0]            = sr_byte_q;
        reg_rdata_o[ST_TFF]         = tff_q;
        reg_rdata_o[ST_WCF]         = wcf_q;
        reg_rdata_o[ST_ERR1]        = err1_q;
        reg_rdata_o[ST_ERR2]        = err2_q;
        reg_rdata_o[ST_WM +: NBANK] = wm_q;
        reg_rdata_o[ST_BUSY]        = eng_busy;
      end
      A_TXD: reg_rdata_o = txd_q;
      A_RXD: reg_rdata_o = rx_w;
      default: reg_rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_cs
    assign cs_no[g] = !(eng_sel && (bank_q == BW'(g)));
  end
endmodule

// File: rtl/sflash_ctrl_chk.sv
module sflash_ctrl_chk #(
  parameter int NBANK = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NBANK-1:0] cs_n_i,
  input logic             sck_i,
  input logic             busy_i,
  input logic             tff_i,
  input logic             err1_i,
  input logic [NBANK-1:0] wm_i,
  input logic             sts_wr_i,
  input logic [31:0]      wdata_i
);
  assert_cs_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_i));

  assert_sck_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_n_i) |-> !sck_i);

  assert_cs_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_n_i) |-> busy_i);

  assert_tff_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tff_i && !(sts_wr_i && !wdata_i[8])) |=> tff_i);

  assert_wm_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_wr_i |=> ((wm_i & $past(wm_i)) == $past(wm_i)));

  assert_err1_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err1_i) |-> (&cs_n_i));
endmodule

bind sflash_ctrl sflash_ctrl_chk #(.NBANK(NBANK)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_no), .sck_i(sck_o),
  .busy_i(eng_busy), .tff_i(tff_q), .err1_i(err1_q), .wm_i(wm_q),
  .sts_wr_i(sts_wr), .wdata_i(reg_wdata_i)
);

// File: tb/sflash_ctrl_tb.sv
`timescale 1ns/1ps
module sflash_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, miso = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sck, mosi;
  logic [3:0] cs_n;
  int n_chk = 0, n_err = 0;
  longint cyc = 0;

  always #5 clk = ~clk;

  sflash_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  // flash model
  wire cs_all = &cs_n;
  logic [7:0] sh, model_sr = 8'h00;
  logic [23:0] resp;
  logic [7:0] rec [8];
  logic [3:0] last_cs;
  int bitc = 0, nbytes = 0, xfers = 0;
  realtime t_sck_prev = 0, sck_per = 0, t_up = 0, t_dn = 0;

  always @(negedge cs_all) begin
    bitc = 0; nbytes = 0; miso = 1'b0; last_cs = cs_n; xfers++; t_dn = $realtime;
  end
  always @(posedge cs_all) t_up = $realtime;
  always @(posedge sck) if (!cs_all) begin
    sh = {sh[6:0], mosi};
    bitc++;
    sck_per = $realtime - t_sck_prev; t_sck_prev = $realtime;
    if (bitc % 8 == 0) begin
      if (nbytes < 8) rec[nbytes] = sh;
      nbytes++;
      if (bitc == 8)
        resp = (sh == 8'h9F) ? 24'h202017 : (sh == 8'h05) ? {model_sr, 16'h0} : 24'h0;
    end
  end
  always @(negedge sck) if (!cs_all) miso = (bitc >= 8 && bitc < 32) ? resp[23-(bitc-8)] : 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int k = 0;
    do begin rd(3'd2, s); k++; end while (s[16] && k < 5000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd2, d); check("R1 status after reset", d, 32'h0);
    rd(3'd0, d); check("R1 config after reset", d, 32'h0);
    check("R1 selects high, clock low", {27'h0, cs_n, sck}, {27'h0, 4'hF, 1'b0});
    wr(3'd0, 32'hFFFF_F20F);
    rd(3'd0, d); check("R1 config mask", d, 32'h1000_820F);
  endtask

  task automatic t_read_id();
    logic [31:0] d;
    wr(3'd3, 32'h0000_009F);
    wr(3'd1, 32'h0000_10B1);
    wait_idle();
    rd(3'd4, d); check("R4 identify reply packing", d, 32'h0017_2020);
    check("R9 bank1 select only", {28'h0, last_cs}, 32'hD);
    check("R3 bit count tx1 rx3", bitc, 32);
    rd(3'd2, d); check("R5 finished flag set", d[8], 1'b1);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R5 write 1 keeps flag", d[8], 1'b1);
    wr(3'd2, 32'hFFFF_FEFF);
    rd(3'd2, d); check("R5 write 0 clears flag", d[8], 1'b0);
  endtask

  task automatic t_tx4();
    wr(3'd3, 32'h0302_01D8);
    wr(3'd1, 32'h0000_0084);
    wait_idle();
    check("R3 byte order", {rec[0], rec[1], rec[2], rec[3]}, 32'hD801_0203);
    check("R3 tx4 bit count", bitc, 32);
    check("R9 bank0 select only", {28'h0, last_cs}, 32'hE);
  endtask

  task automatic t_rx_clamp();
    logic [31:0] d;
    wr(3'd3, 32'h0000_009F);
    wr(3'd1, 32'h0000_00F1);
    wait_idle();
    check("R4 rx length clamp bit count", bitc, 40);
    rd(3'd4, d); check("R4 clamped reply", d, 32'h0017_2020);
  endtask

  task automatic t_period_gap();
    logic [31:0] d;
    wr(3'd0, 32'h1000_030F);
    wr(3'd3, 32'h0000_00AA);
    wr(3'd1, 32'h0000_0081);
    wait_idle();
    check("R2 sck period div 3", int'(sck_per), 60);
    wr(3'd1, 32'h0000_0081);
    check("R9 gap after deselect", (t_dn - t_up) >= 120.0, 1'b1);
    @(posedge cs_all); @(negedge clk);
    rd(3'd2, d); check("R9 busy during gap", d[16], 1'b1);
    wait_idle();
    wr(3'd0, 32'h1000_000F);
    wr(3'd1, 32'h0000_0081);
    wait_idle();
    check("R2 sck period div 0", int'(sck_per), 20);
  endtask

  task automatic t_hw();
    logic [31:0] d;
    wr(3'd0, 32'h0000_020F);
    wr(3'd1, 32'h0000_2800);
    wait_idle();
    check("R6 write-enable opcode", {24'h0, rec[0]}, 32'h06);
    check("R6 one byte", nbytes, 1);
    check("R9 bank2 select", {28'h0, last_cs}, 32'hB);
    rd(3'd2, d); check("R6 bank2 flag", d[15:12], 4'h4);
    model_sr = 8'h03;
    wr(3'd1, 32'h0000_2400);
    wait_idle();
    check("R7 read-status opcode", {24'h0, rec[0]}, 32'h05);
    rd(3'd2, d); check("R7 status byte", d[7:0], 8'h03);
    check("R8 no write complete while busy", d[9], 1'b0);
    model_sr = 8'h00;
    wr(3'd1, 32'h0000_2400);
    wait_idle();
    rd(3'd2, d); check("R8 write complete", {d[9], d[7:0]}, 9'h100);
    wr(3'd2, 32'h0000_0000);
    rd(3'd2, d); check("R8 clear by zero", d[15:8], 8'h00);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    int x0;
    wr(3'd0, 32'h1000_040F);
    wr(3'd3, 32'h0000_009F);
    x0 = xfers;
    wr(3'd1, 32'h0000_00B1);
    wr(3'd1, 32'h0000_3084);
    wait_idle();
    check("R10 one transfer only", xfers - x0, 1);
    rd(3'd1, d); check("R10 command kept", d, 32'h0000_00B1);
    rd(3'd2, d); check("R10 error 2 set", d[11], 1'b1);
    wr(3'd2, 32'h0000_0000);
  endtask

  task automatic t_bad_bank();
    logic [31:0] d;
    int x0;
    wr(3'd0, 32'h1000_0107);
    x0 = xfers;
    wr(3'd1, 32'h0000_3081);
    rd(3'd2, d); check("R11 error 1 next cycle", {d[16], d[10], d[8]}, 3'b010);
    repeat (20) @(negedge clk);
    check("R11 no traffic", xfers - x0, 0);
    check("R11 selects idle", {27'h0, cs_n, sck}, {27'h0, 4'hF, 1'b0});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_id();
    t_tx4();
    t_rx_clamp();
    t_period_gap();
    t_hw();
    t_collide();
    t_bad_bank();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule